// File: doc/BRIEF.md
# Zero-State Synchronized Shoot-Through Injector

This block sits between a three-phase sine-triangle PWM generator and the gate drivers of an inverter bridge that tolerates shoot-through, such as one fed through an impedance network. It receives three upper-switch and three lower-switch gate pulses, which may already contain dead-time. It finds the zero switching states, in which every upper switch or every lower switch is off. In the timed mode it then turns on all six switches for a programmable number of clock cycles. That interval starts in the first cycle of each zero state.

A two-bit mode input selects the behaviour. In the timed mode, the shoot-through starts together with the zero state. It is cut short if the zero state ends early, and it fires at most once per zero state. In the comparator mode, the shoot-through follows two external carrier-comparison flags. In pass-through mode, the gate pulses reach the outputs unchanged. All inputs are registered once, so every output follows its inputs one clock later.

Top module: `zsi_st_injector`

## Requirements
- R1: While reset is high at a clock edge, all six outputs are low after that edge. The timer is idle. A zero state that is already present when reset is released does not start a shoot-through.
- R2: Each output equals its gate input from the previous clock edge, ORed with the shoot-through signal for that cycle. Mode code 2'b00 and mode code 2'b11 are pass-through: the outputs equal the delayed inputs exactly.
- R3: A zero state exists when all three upper pulses are low, or when all three lower pulses are low. Either group alone is enough to trigger.
- R4: In timed mode (code 2'b01), the first registered sample of a zero state drives all six outputs high in that same output cycle. They stay high for exactly the programmed number of cycles if the zero state lasts that long.
- R5: In timed mode, a shoot-through ends in the first cycle whose registered sample is not a zero state. No shoot-through occurs outside a zero state.
- R6: A zero state triggers only one shoot-through, however long it lasts. A move between the upper-group and lower-group zero codes without an intervening active state also triggers only one. A new shoot-through needs the zero state to end and begin again.
- R7: A programmed duration of 0, sampled at the start of a zero state, produces no shoot-through in that zero state.
- R8: The duration is taken only at the start of a zero state. Changing it during an interval does not change that interval's length.
- R9: In comparator mode (code 2'b10), all six outputs are high in every cycle where either comparator flag was high at the previous clock edge. When neither flag was high, the outputs follow the inputs.
- R10: In timed mode the comparator flags have no effect. In pass-through mode, neither the comparator flags nor the zero states have any effect.
- R11: Leaving timed mode cancels any interval in progress. Returning to timed mode inside the same zero state does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00/11 pass-through, 01 timed, 10 comparator |
| st_len | input | ST_W | Shoot-through length in clock cycles |
| cmp_hi | input | 1 | Carrier above positive reference |
| cmp_lo | input | 1 | Carrier below negative reference |
| gate_up_in | input | NPH | Upper-switch gate pulses |
| gate_dn_in | input | NPH | Lower-switch gate pulses |
| gate_up_out | output | NPH | Upper-switch gates with shoot-through |
| gate_dn_out | output | NPH | Lower-switch gates with shoot-through |

## Verification
Every output is due one clock edge after the inputs that cause it. A timed shoot-through appears in that same output cycle as the first registered zero-state sample, and it lasts for the number of cycles latched at that edge. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares all six outputs, on the next falling edge, with a behavioural model that tracks the age of the current zero state. Directed segments target starts, cut-offs, mode switches and duration changes. A randomized stretch then mixes all of these.

// File: rtl/zsi_pkg.sv
package zsi_pkg;
    typedef enum logic [1:0] {
        MODE_PASS     = 2'b00,
        MODE_TIMED    = 2'b01,
        MODE_CMP      = 2'b10,
        MODE_PASS_ALT = 2'b11
    } st_mode_e;
endpackage

// File: rtl/zsi_in_stage.sv
module zsi_in_stage #(
    parameter int NPH  = 3,
    parameter int ST_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode,
    input  logic [ST_W-1:0] st_len,
    input  logic            cmp_hi,
    input  logic            cmp_lo,
    input  logic [NPH-1:0]  up_in,
    input  logic [NPH-1:0]  dn_in,
    output zsi_pkg::st_mode_e mode_q,
    output logic [ST_W-1:0] len_q,
    output logic            cmp_q,
    output logic [NPH-1:0]  up_q,
    output logic [NPH-1:0]  dn_q
);
    import zsi_pkg::*;

    typedef struct packed {
        st_mode_e        mode;
        logic [ST_W-1:0] len;
        logic            cmp;
        logic [NPH-1:0]  up;
        logic [NPH-1:0]  dn;
    } stage_t;

    stage_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.mode = st_mode_e'(mode);
        nxt_d.len  = st_len;
        nxt_d.cmp  = cmp_hi | cmp_lo;
        nxt_d.up   = up_in;
        nxt_d.dn   = dn_in;
        if (rst) begin
            nxt_d      = '0;
            nxt_d.mode = MODE_PASS;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign mode_q = cur_q.mode;
    assign len_q  = cur_q.len;
    assign cmp_q  = cur_q.cmp;
    assign up_q   = cur_q.up;
    assign dn_q   = cur_q.dn;
endmodule

// File: rtl/zsi_zero_detect.sv
module zsi_zero_detect #(
    parameter int NPH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NPH-1:0] up_q,
    input  logic [NPH-1:0] dn_q,
    output logic           zero,
    output logic           zero_rise
);
    typedef struct packed {
        logic zero_prev;
    } det_t;

    det_t cur_q, nxt_d;
    logic any_up, any_dn;

    always_comb begin
        any_up          = |up_q;
        any_dn          = |dn_q;
        zero            = ~(any_up & any_dn);
        zero_rise       = zero & ~cur_q.zero_prev;
        nxt_d           = cur_q;
        nxt_d.zero_prev = zero;
        if (rst) begin
            nxt_d.zero_prev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end
endmodule

// File: rtl/zsi_st_timer.sv
module zsi_st_timer #(
    parameter int ST_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            zero,
    input  logic            zero_rise,
    input  logic [ST_W-1:0] len_q,
    output logic            st_timed
);
    localparam logic [ST_W-1:0] ONE = ST_W'(1);

    typedef struct packed {
        logic [ST_W-1:0] left;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        st_timed = 1'b0;
        if (!enable || !zero) begin
            nxt_d.left = '0;
        end else if (zero_rise) begin
            st_timed   = (len_q != '0);
            nxt_d.left = (len_q != '0) ? (len_q - ONE) : '0;
        end else if (cur_q.left != '0) begin
            st_timed   = 1'b1;
            nxt_d.left = cur_q.left - ONE;
        end
        if (rst) begin
            nxt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end
endmodule

// File: rtl/zsi_gate_merge.sv
module zsi_gate_merge #(
    parameter int NPH = 3
) (
    input  zsi_pkg::st_mode_e mode_q,
    input  logic              st_timed,
    input  logic              cmp_q,
    input  logic [NPH-1:0]    up_q,
    input  logic [NPH-1:0]    dn_q,
    output logic [NPH-1:0]    up_out,
    output logic [NPH-1:0]    dn_out
);
    import zsi_pkg::*;

    logic timed_term, cmp_term, st_all;

    always_comb begin
        timed_term = st_timed & (mode_q == MODE_TIMED);
        cmp_term   = cmp_q & (mode_q == MODE_CMP);
        st_all     = timed_term | cmp_term;
    end

    for (genvar ph = 0; ph < NPH; ph++) begin : g_leg
        assign up_out[ph] = up_q[ph] | st_all;
        assign dn_out[ph] = dn_q[ph] | st_all;
    end
endmodule

// File: rtl/zsi_st_injector.sv
module zsi_st_injector #(
    parameter int NPH  = 3,
    parameter int ST_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode,
    input  logic [ST_W-1:0] st_len,
    input  logic            cmp_hi,
    input  logic            cmp_lo,
    input  logic [NPH-1:0]  gate_up_in,
    input  logic [NPH-1:0]  gate_dn_in,
    output logic [NPH-1:0]  gate_up_out,
    output logic [NPH-1:0]  gate_dn_out
);
    import zsi_pkg::*;

    st_mode_e        mode_q;
    logic [ST_W-1:0] len_q;
    logic            cmp_q;
    logic [NPH-1:0]  up_q, dn_q;
    logic            zero, zero_rise, st_timed, timed_en;

    zsi_in_stage #(.NPH(NPH), .ST_W(ST_W)) u_in (
        .clk(clk), .rst(rst), .mode(mode), .st_len(st_len),
        .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
        .up_in(gate_up_in), .dn_in(gate_dn_in),
        .mode_q(mode_q), .len_q(len_q), .cmp_q(cmp_q),
        .up_q(up_q), .dn_q(dn_q)
    );

    zsi_zero_detect #(.NPH(NPH)) u_det (
        .clk(clk), .rst(rst), .up_q(up_q), .dn_q(dn_q),
        .zero(zero), .zero_rise(zero_rise)
    );

    assign timed_en = (mode_q == MODE_TIMED);

    zsi_st_timer #(.ST_W(ST_W)) u_tmr (
        .clk(clk), .rst(rst), .enable(timed_en), .zero(zero),
        .zero_rise(zero_rise), .len_q(len_q), .st_timed(st_timed)
    );

    zsi_gate_merge #(.NPH(NPH)) u_merge (
        .mode_q(mode_q), .st_timed(st_timed), .cmp_q(cmp_q),
        .up_q(up_q), .dn_q(dn_q),
        .up_out(gate_up_out), .dn_out(gate_dn_out)
    );
endmodule

// File: rtl/zsi_st_checker.sv
module zsi_st_checker #(
    parameter int NPH  = 3,
    parameter int ST_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      mode,
    input logic [ST_W-1:0] st_len,
    input logic            cmp_hi,
    input logic            cmp_lo,
    input logic [NPH-1:0]  gate_up_in,
    input logic [NPH-1:0]  gate_dn_in,
    input logic [NPH-1:0]  gate_up_out,
    input logic [NPH-1:0]  gate_dn_out
);
    logic live_q, live2_q, in_rst_q;

    always_ff @(posedge clk) begin
        in_rst_q <= rst;
        live_q   <= !rst;
        live2_q  <= live_q && !rst;
    end

    // R1: outputs low after a reset edge
    always @(negedge clk) begin
        if (in_rst_q === 1'b1) begin
            a_r1_reset_low: assert (gate_up_out == '0 && gate_dn_out == '0);
        end
    end

    a_r2_pass_exact: assert property (@(posedge clk) disable iff (rst)
        (live_q && ($past(mode) == 2'b00 || $past(mode) == 2'b11))
        |-> (gate_up_out == $past(gate_up_in) && gate_dn_out == $past(gate_dn_in)));

    a_r5_no_st_active: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(mode) == 2'b01 && $past(gate_up_in) != '0 && $past(gate_dn_in) != '0)
        |-> (gate_up_out == $past(gate_up_in) && gate_dn_out == $past(gate_dn_in)));

    a_r4_rise_fires: assert property (@(posedge clk) disable iff (rst)
        (live2_q && $past(mode) == 2'b01 && $past(st_len) != '0
         && ($past(gate_up_in) == '0 || $past(gate_dn_in) == '0)
         && $past(gate_up_in, 2) != '0 && $past(gate_dn_in, 2) != '0)
        |-> (&gate_up_out && &gate_dn_out));

    a_r9_cmp_fill: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(mode) == 2'b10 && ($past(cmp_hi) || $past(cmp_lo)))
        |-> (&gate_up_out && &gate_dn_out));

    a_r9_cmp_quiet: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(mode) == 2'b10 && !$past(cmp_hi) && !$past(cmp_lo))
        |-> (gate_up_out == $past(gate_up_in) && gate_dn_out == $past(gate_dn_in)));
endmodule

bind zsi_st_injector zsi_st_checker #(.NPH(NPH), .ST_W(ST_W)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .st_len(st_len),
    .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .gate_up_in(gate_up_in), .gate_dn_in(gate_dn_in),
    .gate_up_out(gate_up_out), .gate_dn_out(gate_dn_out)
);

// File: tb/zsi_st_injector_tb.sv
`timescale 1ns/1ps
module zsi_st_injector_tb;
    localparam int NPH  = 3;
    localparam int ST_W = 8;
    localparam int IDLE_AGE = 100000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      mode = 2'b00;
    logic [ST_W-1:0] st_len = '0;
    logic            cmp_hi = 1'b0, cmp_lo = 1'b0;
    logic [NPH-1:0]  up_in = '0, dn_in = '0;
    logic [NPH-1:0]  up_out, dn_out;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    int  m_age = IDLE_AGE;
    int  m_len = 0;
    bit  m_zero_prev = 1'b1;
    logic [NPH-1:0] e_up, e_dn;

    always #10 clk = ~clk;

    zsi_st_injector #(.NPH(NPH), .ST_W(ST_W)) u_dut (
        .clk(clk), .rst(rst), .mode(mode), .st_len(st_len),
        .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
        .gate_up_in(up_in), .gate_dn_in(dn_in),
        .gate_up_out(up_out), .gate_dn_out(dn_out)
    );

    task automatic compare(input string tag);
        checks++;
        if (up_out !== e_up || dn_out !== e_dn) begin
            fails++;
            $display("FAIL %s t=%0t actual up=%b dn=%b expected up=%b dn=%b",
                     tag, $time, up_out, dn_out, e_up, e_dn);
        end
    endtask

    // one cycle: drive, let a rising edge register, model it, compare at falling edge
    task automatic step(input logic [NPH-1:0] u, input logic [NPH-1:0] d,
                        input bit hi, input bit lo, input logic [1:0] md,
                        input int len, input string tag);
        bit zs, st;
        up_in = u; dn_in = d; cmp_hi = hi; cmp_lo = lo; mode = md;
        st_len = ST_W'(len);
        @(posedge clk);
        zs = (u == '0) || (d == '0);
        if (md != 2'b01 || !zs) begin
            m_age = IDLE_AGE;
        end else if (!m_zero_prev) begin
            m_age = 0;
            m_len = len;
        end else if (m_age < IDLE_AGE) begin
            m_age++;
        end
        m_zero_prev = zs;
        st = 1'b0;
        if (md == 2'b01) st = zs && (m_age < m_len);
        if (md == 2'b10) st = hi || lo;
        e_up = u | {NPH{st}};
        e_dn = d | {NPH{st}};
        @(negedge clk);
        compare(tag);
    endtask

    task automatic steps(input int n, input logic [NPH-1:0] u, input logic [NPH-1:0] d,
                         input bit hi, input bit lo, input logic [1:0] md,
                         input int len, input string tag);
        for (int i = 0; i < n; i++) step(u, d, hi, lo, md, len, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        // R1: reset with a zero state present
        rst = 1'b1; mode = 2'b01; st_len = 8'd4; up_in = 3'b000; dn_in = 3'b111;
        e_up = '0; e_dn = '0;
        repeat (3) begin
            @(negedge clk);
            compare("R1");
        end
        m_zero_prev = 1'b1; m_age = IDLE_AGE;
        rst = 1'b0;
        steps(4, 3'b000, 3'b111, 0, 0, 2'b01, 4, "R1");

        // R2: pass-through patterns in both pass codes
        step(3'b101, 3'b010, 0, 0, 2'b00, 4, "R2");
        step(3'b000, 3'b111, 1, 1, 2'b00, 4, "R2");
        step(3'b110, 3'b001, 0, 1, 2'b11, 4, "R2");
        step(3'b111, 3'b000, 1, 0, 2'b11, 4, "R2");
        step(3'b011, 3'b101, 0, 0, 2'b00, 4, "R2");

        // R3 / R4: upper-group zero then lower-group zero, length 3
        steps(2, 3'b101, 3'b010, 0, 0, 2'b01, 3, "R4");
        steps(8, 3'b000, 3'b111, 0, 0, 2'b01, 3, "R4");
        steps(3, 3'b110, 3'b001, 0, 0, 2'b01, 3, "R3");
        steps(6, 3'b111, 3'b000, 0, 0, 2'b01, 3, "R3");
        steps(2, 3'b100, 3'b011, 0, 0, 2'b01, 3, "R3");
        // dead-time style: both groups partly low, one group all low
        steps(5, 3'b000, 3'b011, 0, 0, 2'b01, 2, "R3");
        steps(2, 3'b100, 3'b011, 0, 0, 2'b01, 2, "R3");

        // R5: zero state shorter than the programmed length
        steps(4, 3'b000, 3'b111, 0, 0, 2'b01, 10, "R5");
        steps(3, 3'b010, 3'b101, 0, 0, 2'b01, 10, "R5");
        step(3'b000, 3'b111, 0, 0, 2'b01, 10, "R5");
        steps(2, 3'b010, 3'b101, 0, 0, 2'b01, 10, "R5");

        // R6: long zero state, hop between zero codes, no retrigger
        steps(4, 3'b000, 3'b111, 0, 0, 2'b01, 2, "R6");
        steps(4, 3'b111, 3'b000, 0, 0, 2'b01, 2, "R6");
        steps(4, 3'b000, 3'b000, 0, 0, 2'b01, 2, "R6");
        steps(2, 3'b001, 3'b110, 0, 0, 2'b01, 2, "R6");

        // R7: zero length
        steps(5, 3'b000, 3'b111, 0, 0, 2'b01, 0, "R7");
        steps(2, 3'b001, 3'b110, 0, 0, 2'b01, 0, "R7");

        // R8: change length inside an interval
        step(3'b000, 3'b111, 0, 0, 2'b01, 5, "R8");
        steps(7, 3'b000, 3'b111, 0, 0, 2'b01, 1, "R8");
        steps(2, 3'b001, 3'b110, 0, 0, 2'b01, 1, "R8");
        steps(4, 3'b000, 3'b111, 0, 0, 2'b01, 6, "R8");
        steps(2, 3'b001, 3'b110, 0, 0, 2'b01, 6, "R8");

        // R9: comparator mode
        step(3'b101, 3'b010, 1, 0, 2'b10, 3, "R9");
        step(3'b101, 3'b010, 0, 1, 2'b10, 3, "R9");
        step(3'b101, 3'b010, 0, 0, 2'b10, 3, "R9");
        step(3'b000, 3'b111, 0, 0, 2'b10, 3, "R9");
        step(3'b000, 3'b111, 1, 1, 2'b10, 3, "R9");
        step(3'b011, 3'b100, 0, 0, 2'b10, 3, "R9");

        // R10: comparator flags ignored in timed and pass modes
        steps(3, 3'b011, 3'b100, 1, 1, 2'b01, 3, "R10");
        steps(3, 3'b000, 3'b111, 1, 0, 2'b01, 1, "R10");
        steps(2, 3'b011, 3'b100, 0, 1, 2'b00, 3, "R10");
        steps(3, 3'b000, 3'b111, 1, 1, 2'b00, 3, "R10");

        // R11: leave timed mode mid-interval, return in same zero state
        steps(2, 3'b011, 3'b100, 0, 0, 2'b01, 6, "R11");
        steps(2, 3'b000, 3'b111, 0, 0, 2'b01, 6, "R11");
        step(3'b000, 3'b111, 0, 0, 2'b00, 6, "R11");
        steps(4, 3'b000, 3'b111, 0, 0, 2'b01, 6, "R11");
        steps(2, 3'b011, 3'b100, 0, 0, 2'b01, 6, "R11");

        // mixed random stretch across all requirements (R4 focus)
        for (int k = 0; k < 3000; k++) begin
            logic [NPH-1:0] ru, rd;
            logic [1:0] rm;
            int r;
            r  = $urandom_range(0, 9);
            ru = (r < 4) ? 3'b000 : NPH'($urandom);
            rd = (r == 4) ? 3'b000 : NPH'($urandom);
            rm = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b01;
            step(ru, rd, 1'($urandom), 1'($urandom), rm, $urandom_range(0, 6), "R4");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule